// File: doc/BRIEF.md
# Modified Immediate Constant Expander

This block turns the 12-bit packed immediate carried inside a 32-bit instruction word into the full 32-bit constant that the datapath operates on, together with the shifter carry that an instruction using the constant would set. Two packing schemes are supported and chosen by a single mode input. The classic scheme rotates one byte right by an even amount. The compact scheme either repeats one byte across the word in one of four layouts or rotates a seven-bit value with a forced leading one.

Alongside the constant, the block produces the plain zero-extended 12-bit immediate of the compact scheme and two word-scaled offsets used by load and store forms. It also raises a flag for replicate patterns that encode no useful constant. The expansion logic is combinational. All results are captured in output registers, so they appear one clock after the instruction word is presented. Decoding of the instruction beyond field extraction is left to the surrounding logic.

Top module: `imm_expander`

## Requirements
- R1: While `rst` is high on a rising edge, every output register is cleared to zero on that edge.
- R2: With `mode_compact`=0, `const_value` one clock after sampling equals `insn_word[7:0]`, zero-extended, rotated right by 2×`insn_word[11:8]` bit positions.
- R3: With `mode_compact`=0, `carry_out` equals the sampled `carry_in` when `insn_word[11:8]` is 0, and otherwise equals bit 31 of the expanded constant.
- R4: The compact 12-bit immediate is assembled as {`insn_word[26]`, `insn_word[14:12]`, `insn_word[7:0]`}, bit 26 being the most significant. `imm12_zext` carries it zero-extended in both modes.
- R5: With `mode_compact`=1 and imm12[11:10]=00, byte B=imm12[7:0] is laid out by imm12[9:8]: 00 gives 0x000000BB, 01 gives 0x00BB00BB, 10 gives 0xBB00BB00, 11 gives 0xBBBBBBBB.
- R6: With `mode_compact`=1 and imm12[11:10]=00, `carry_out` equals the sampled `carry_in`.
- R7: With `mode_compact`=1 and imm12[11:10]≠00, `const_value` is the 8-bit value {1, imm12[6:0]}, zero-extended, rotated right by imm12[11:7], and `carry_out` is bit 31 of that result.
- R8: `off7_x4` equals `insn_word[6:0]`×4 and `off8_x4` equals `insn_word[7:0]`×4, both zero-extended, in both modes.
- R9: `reserved_pat` is 1 only when `mode_compact`=1, imm12[11:10]=00, imm12[9:8]≠00 and imm12[7:0]=0. In every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| insn_word | input | 32 | Instruction word holding the packed immediate |
| carry_in | input | 1 | Current shifter carry flag |
| mode_compact | input | 1 | 0 selects the classic scheme, 1 the compact scheme |
| const_value | output | 32 | Expanded 32-bit constant, registered |
| carry_out | output | 1 | Shifter carry produced by the expansion, registered |
| imm12_zext | output | 32 | Compact 12-bit immediate, zero-extended, registered |
| off7_x4 | output | 32 | insn_word[6:0] scaled by four, registered |
| off8_x4 | output | 32 | insn_word[7:0] scaled by four, registered |
| reserved_pat | output | 1 | Replicate pattern with a zero byte in compact mode, registered |

## Verification
The assertions take the word, carry and mode to be known and settled at each rising edge. They relate every registered output to the inputs sampled one edge earlier, so they are meaningful only once reset has been released. The stimulus is applied on falling edges and reset is held over the first edges. Every one of the 4096 packed immediates is then swept in both modes with both carry values, and the bits of the word that the expansion does not use are filled with varying values to show that they do not matter.

// File: rtl/imm_exp_pkg.sv
package imm_exp_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 12;
  localparam int BYTE_W  = 8;
  localparam int ROT_W   = $clog2(WORD_W);

  typedef enum logic {
    SCHEME_CLASSIC = 1'b0,
    SCHEME_COMPACT = 1'b1
  } scheme_e;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              carry;
    logic              reserved;
  } expand_t;
endpackage

// File: rtl/imm_rotr.sv
module imm_rotr #(
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [2*W-1:0] doubled;
  assign doubled = {din, din};
  assign dout    = W'(doubled >> amt);
endmodule

// File: rtl/imm_classic_path.sv
module imm_classic_path
  import imm_exp_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int BW     = BYTE_W
) (
  input  logic [BW+3:0] field,
  input  logic          carry_in,
  output expand_t       res
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   rot_amt;
  logic [DATA_W-1:0] rotated;

  assign rot_amt = SH_W'({field[BW+3:BW], 1'b0});

  imm_rotr #(.W(DATA_W), .SH_W(SH_W)) u_rot (
    .din  ({{(DATA_W-BW){1'b0}}, field[BW-1:0]}),
    .amt  (rot_amt),
    .dout (rotated)
  );

  always_comb begin
    res.value    = rotated;
    res.carry    = (field[BW+3:BW] == '0) ? carry_in : rotated[DATA_W-1];
    res.reserved = 1'b0;
  end
endmodule

// File: rtl/imm_compact_path.sv
module imm_compact_path
  import imm_exp_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int BW     = BYTE_W
) (
  input  logic [BW+3:0] imm12,
  input  logic          carry_in,
  output expand_t       res
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int LANES = DATA_W / BW;

  logic [BW-1:0]     byte_v;
  logic [1:0]        layout;
  logic              repl_sel;
  logic [DATA_W-1:0] repl_val;
  logic [DATA_W-1:0] rot_val;

  assign byte_v   = imm12[BW-1:0];
  assign layout   = imm12[BW+1:BW];
  assign repl_sel = (imm12[BW+3:BW+2] == 2'b00);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic lane_on;
    assign lane_on = (layout == 2'b11)
                   | ((layout == 2'b00) && (k == 0))
                   | ((layout == 2'b01) && (k % 2 == 0))
                   | ((layout == 2'b10) && (k % 2 == 1));
    assign repl_val[k*BW +: BW] = lane_on ? byte_v : '0;
  end

  imm_rotr #(.W(DATA_W), .SH_W(SH_W)) u_rot (
    .din  ({{(DATA_W-BW){1'b0}}, 1'b1, imm12[BW-2:0]}),
    .amt  (imm12[BW+3:BW-1]),
    .dout (rot_val)
  );

  always_comb begin
    if (repl_sel) begin
      res.value    = repl_val;
      res.carry    = carry_in;
      res.reserved = (layout != 2'b00) && (byte_v == '0);
    end else begin
      res.value    = rot_val;
      res.carry    = rot_val[DATA_W-1];
      res.reserved = 1'b0;
    end
  end
endmodule

// File: rtl/imm_expander.sv
module imm_expander
  import imm_exp_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] insn_word,
  input  logic              carry_in,
  input  logic              mode_compact,
  output logic [DATA_W-1:0] const_value,
  output logic              carry_out,
  output logic [DATA_W-1:0] imm12_zext,
  output logic [DATA_W-1:0] off7_x4,
  output logic [DATA_W-1:0] off8_x4,
  output logic              reserved_pat
);
  localparam int IMM_W = FIELD_W;

  logic [IMM_W-1:0] imm12;
  expand_t          res_classic;
  expand_t          res_compact;
  expand_t          res_sel;
  scheme_e          scheme;
  logic             unused_bits;

  assign imm12       = {insn_word[26], insn_word[14:12], insn_word[7:0]};
  assign scheme      = scheme_e'(mode_compact);
  assign unused_bits = ^{insn_word[DATA_W-1:27], insn_word[25:15]};

  imm_classic_path #(.DATA_W(DATA_W)) u_classic (
    .field    (insn_word[IMM_W-1:0]),
    .carry_in (carry_in),
    .res      (res_classic)
  );

  imm_compact_path #(.DATA_W(DATA_W)) u_compact (
    .imm12    (imm12),
    .carry_in (carry_in),
    .res      (res_compact)
  );

  assign res_sel = (scheme == SCHEME_COMPACT) ? res_compact : res_classic;

  always_ff @(posedge clk) begin
    if (rst) begin
      const_value  <= '0;
      carry_out    <= 1'b0;
      imm12_zext   <= '0;
      off7_x4      <= '0;
      off8_x4      <= '0;
      reserved_pat <= 1'b0;
    end else begin
      const_value  <= res_sel.value;
      carry_out    <= res_sel.carry;
      imm12_zext   <= {{(DATA_W-IMM_W){1'b0}}, imm12};
      off7_x4      <= {{(DATA_W-9){1'b0}}, insn_word[6:0], 2'b00};
      off8_x4      <= {{(DATA_W-10){1'b0}}, insn_word[7:0], 2'b00};
      reserved_pat <= res_sel.reserved;
    end
  end

  // R3: zero classic rotate keeps the incoming carry
  p_classic_carry_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_compact && insn_word[11:8] == 4'd0) |=> (carry_out == $past(carry_in)));

  // R2: zero classic rotate leaves the byte in place
  p_classic_norot_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode_compact && insn_word[11:8] == 4'd0) |=>
      (const_value == {{(DATA_W-8){1'b0}}, $past(insn_word[7:0])}));

  // R6: replicate path keeps the incoming carry
  p_repl_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_compact && insn_word[26] == 1'b0 && insn_word[14] == 1'b0) |=>
      (carry_out == $past(carry_in)));

  // R7: rotate path always holds exactly the leading one plus seven payload bits
  p_rot_carry_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_compact && (insn_word[26] || insn_word[14])) |=>
      (carry_out == const_value[DATA_W-1]) &&
      ($countones(const_value) == $countones({1'b1, $past(insn_word[6:0])})));

  // R9: the reserved flag never rises in classic mode
  p_reserved_classic_r9: assert property (@(posedge clk) disable iff (rst)
    !mode_compact |=> !reserved_pat);

  // R8: scaled offsets always have their two low bits clear
  p_offset_align_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (off7_x4[1:0] == 2'b00) && (off8_x4[1:0] == 2'b00));
endmodule

// File: tb/sim_imm_expander.sv
`timescale 1ns/1ps
module sim_imm_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn_word = 32'h0;
  logic        carry_in = 1'b0;
  logic        mode_compact = 1'b0;
  logic [31:0] const_value, imm12_zext, off7_x4, off8_x4;
  logic        carry_out, reserved_pat;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  imm_expander u0 (
    .clk(clk), .rst(rst), .insn_word(insn_word), .carry_in(carry_in),
    .mode_compact(mode_compact), .const_value(const_value), .carry_out(carry_out),
    .imm12_zext(imm12_zext), .off7_x4(off7_x4), .off8_x4(off8_x4),
    .reserved_pat(reserved_pat)
  );

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    logic [31:0] r = v;
    for (int i = 0; i < n % 32; i++) r = {r[0], r[31:1]};
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h word=%h mode=%0d cin=%0d",
               req, act, exp, insn_word, mode_compact, carry_in);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic m, input logic c);
    int          imm;
    int          b;
    logic [31:0] ev;
    logic        ec;
    logic        er;
    @(negedge clk);
    insn_word = w; mode_compact = m; carry_in = c;
    imm = {w[26], w[14:12], w[7:0]};
    er  = 1'b0;
    if (!m) begin
      ev = rotr(32'(w[7:0]), 2 * int'(w[11:8]));
      ec = (w[11:8] == 0) ? c : ev[31];
    end else begin
      b = imm % 256;
      if (imm / 1024 == 0) begin
        case ((imm / 256) % 4)
          0: ev = b;
          1: ev = b * 65537;
          2: ev = b * 65537 * 256;
          default: ev = b * 16843009;
        endcase
        ec = c;
        er = ((imm / 256) % 4 != 0) && (b == 0);
      end else begin
        ev = rotr(32'(128 + imm % 128), imm / 128);
        ec = ev[31];
      end
    end
    @(negedge clk);
    if (!m) begin
      chk("R2 classic value", const_value, ev);
      chk("R3 classic carry", {31'b0, carry_out}, {31'b0, ec});
    end else if (imm / 1024 == 0) begin
      chk("R5 replicate value", const_value, ev);
      chk("R6 replicate carry", {31'b0, carry_out}, {31'b0, ec});
    end else begin
      chk("R7 rotate value", const_value, ev);
      chk("R7 rotate carry", {31'b0, carry_out}, {31'b0, ec});
    end
    chk("R4 imm12", imm12_zext, 32'(imm));
    chk("R8 off7", off7_x4, 32'(int'(w[6:0]) * 4));
    chk("R8 off8", off8_x4, 32'(int'(w[7:0]) * 4));
    chk("R9 reserved", {31'b0, reserved_pat}, {31'b0, er});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    insn_word = 32'hFFFF_FFFF; carry_in = 1'b1; mode_compact = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", const_value, 32'h0);
    chk("R1 reset carry", {31'b0, carry_out}, 32'h0);
    chk("R1 reset imm12", imm12_zext, 32'h0);
    chk("R1 reset off7", off7_x4, 32'h0);
    chk("R1 reset off8", off8_x4, 32'h0);
    chk("R1 reset flag", {31'b0, reserved_pat}, 32'h0);
    rst = 1'b0;

    for (int mode = 0; mode < 2; mode++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int i = 0; i < 4096; i++) begin
          logic [31:0] w;
          logic [11:0] f;
          w = $urandom;
          f = 12'(i);
          if (mode == 0) w[11:0] = f;
          else begin
            w[26] = f[11]; w[14:12] = f[10:8]; w[7:0] = f[7:0];
          end
          apply(w, mode[0], cin[0]);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule